// File: doc/BRIEF.md
# Control Register Write Unit

This unit owns the write side of three processor control registers: a mode register (protection, FPU trap control, write protection and paging enables), a page-table base register, and a feature register (paging extensions, SSE enable, supervisor-access prevention, protection keys). A single strobe carries a register select and the write data. Each write takes effect at the next rising clock edge. The same edge produces a one-cycle translation-cache flush pulse whenever the write changes state that cached translations depend on.

The unit also keeps the hidden mode flags that the rest of the core reads in place of decoding the architectural registers. It tracks long-mode activation and deactivation as paging is switched on and off. A 64-bit-mode enable input and a page-extension bit gate that activation. When long mode is left, a one-cycle pulse tells the fetch logic to cut the instruction pointer to 32 bits. Feature bits that the capability inputs do not report are dropped before they are stored. The segment loader updates the 64-bit-code flag and the address-add flag through its own strobe.

Top module: `ctrlreg_write_unit`

## Requirements
- R1: After reset the mode register reads 0x00000010, the base and feature registers read 0, long mode is inactive, both pulses are low and the hidden flags read 0x002. Only the address-add flag is set.
- R2: Bit 4 of the mode register is always stored as 1, whatever the write data holds.
- R3: A mode-register write raises the flush pulse for one cycle only if bit 0 (protection), bit 16 (write protect) or bit 31 (paging) differs from the stored value.
- R4: A mode-register write that takes bit 31 from 0 to 1 while the 64-bit-mode enable input is high activates long mode only if feature bit 5 is set. Otherwise the write is dropped entirely: no register or flag changes and no flush.
- R5: A mode-register write that takes bit 31 from 1 to 0 while long mode is active clears long mode and the 64-bit-code flag. It also raises the truncate pulse for one cycle.
- R6: Hidden flag bits are: 0 protection (mode bit 0), 1 address-add, 2 MP, 3 EM, 4 TS (mode bits 1, 2, 3), 5 long-mode-active, 6 64-bit code, 7 SSE-enable (feature bit 9), 8 supervisor-access-prevention (feature bit 21). The address-add flag reads 1 whenever mode bit 0 is 0.
- R7: A base-register write always stores the data. It raises the flush pulse only while mode bit 31 is set.
- R8: A feature-register write raises the flush pulse if the stored value changes in any of bits 4, 5, 7, 12, 20 or 21. A change in any other bit alone does not flush.
- R9: Feature bits 9, 21, 22 and 24 are stored as 0 when the SSE, access-prevention, protection-key or supervisor-key capability input is 0, respectively. The flush decision and the hidden flags use the masked value.
- R10: Select codes are 0 mode, 1 base, 2 feature. A strobe with select 3 changes nothing and raises no pulse.
- R11: A segment-load strobe stores the address-add input and sets the 64-bit-code flag to the long-code input ANDed with the current long-mode state. When it falls in the same cycle as a long-mode exit, the exit wins and the flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select (0 mode, 1 base, 2 feature, 3 none) |
| wr_data | input | REG_W | Write data |
| lme | input | 1 | 64-bit-mode enable from the extended feature register |
| cap_sse | input | 1 | SSE supported |
| cap_smap | input | 1 | Supervisor-access prevention supported |
| cap_pku | input | 1 | User protection keys supported |
| cap_pks | input | 1 | Supervisor protection keys supported |
| seg_ld | input | 1 | Segment-load strobe |
| seg_long | input | 1 | Loaded code segment is a 64-bit segment |
| seg_addadd | input | 1 | Address-add value from the segment loader |
| mode_reg | output | REG_W | Stored mode register |
| base_reg | output | REG_W | Stored page-table base register |
| feat_reg | output | REG_W | Stored feature register |
| hid_flags | output | 9 | Hidden mode flags, layout in R6 |
| lma_out | output | 1 | Long mode active |
| flush_pulse | output | 1 | One-cycle translation-cache flush |
| trunc_pulse | output | 1 | One-cycle instruction-pointer truncate request |

## Verification
The collision that matters is a segment load in the same cycle as a mode write that leaves long mode. The load wants to set the 64-bit-code flag from the still-active long mode, and the exit wants to clear it. The bench first enters long mode and loads a 64-bit segment. It then issues a paging-off write together with a segment-load strobe that asks for long code. The expected result is a cleared 64-bit-code flag, long mode inactive, and truncate and flush pulses in the following cycle. The mirror case, a load in the same cycle as long-mode entry, is judged against the pre-entry state.

// File: rtl/ctrlreg_pkg.sv
package ctrlreg_pkg;

   // mode register bit positions
   localparam int MB_PE  = 0;
   localparam int MB_MP  = 1;
   localparam int MB_EM  = 2;
   localparam int MB_TS  = 3;
   localparam int MB_ET  = 4;
   localparam int MB_WP  = 16;
   localparam int MB_PG  = 31;

   // feature register bit positions
   localparam int FB_PSE   = 4;
   localparam int FB_PAE   = 5;
   localparam int FB_PGE   = 7;
   localparam int FB_SSE   = 9;
   localparam int FB_LA57  = 12;
   localparam int FB_SMEP  = 20;
   localparam int FB_SMAP  = 21;
   localparam int FB_PKE   = 22;
   localparam int FB_PKS   = 24;

   // hidden flag layout
   localparam int HF_PROT  = 0;
   localparam int HF_ADD   = 1;
   localparam int HF_MP    = 2;
   localparam int HF_EM    = 3;
   localparam int HF_TS    = 4;
   localparam int HF_LMA   = 5;
   localparam int HF_CS64  = 6;
   localparam int HF_SSE   = 7;
   localparam int HF_SMAP  = 8;
   localparam int HF_W     = 9;

   localparam int MIN_REG_W = 32;

   typedef enum logic [1:0] {
      SEL_MODE = 2'd0,
      SEL_BASE = 2'd1,
      SEL_FEAT = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/ctrlreg_mode.sv
module ctrlreg_mode
   import ctrlreg_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter bit LONG_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wr_data,
   input  logic             lme,
   input  logic             pae,
   input  logic             seg_ld,
   input  logic             seg_long,
   input  logic             seg_addadd,
   output logic [REG_W-1:0] cr0_q,
   output logic             lma_q,
   output logic             cs64_q,
   output logic             addadd_q,
   output logic             trunc_q,
   output logic             flush_req
);

   localparam logic [REG_W-1:0] ET_BIT   = REG_W'(1) << MB_ET;
   localparam logic [REG_W-1:0] CHG_MASK = (REG_W'(1) << MB_PE) |
                                           (REG_W'(1) << MB_WP) |
                                           (REG_W'(1) << MB_PG);
   localparam logic [REG_W-1:0] RST_VAL  = ET_BIT;

   logic old_pg, new_pg;
   logic lm_enter, lm_exit, discard, accept;

   always_comb begin
      old_pg    = cr0_q[MB_PG];
      new_pg    = wr_data[MB_PG];
      lm_enter  = LONG_MODE && wr && !old_pg && new_pg && lme;
      discard   = lm_enter && !pae;
      lm_exit   = LONG_MODE && wr && old_pg && !new_pg && lma_q;
      accept    = wr && !discard;
      flush_req = accept && (|((wr_data ^ cr0_q) & CHG_MASK));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr0_q <= RST_VAL;
      end else if (accept) begin
         cr0_q <= wr_data | ET_BIT;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addadd_q <= 1'b0;
      end else if (seg_ld) begin
         addadd_q <= seg_addadd;
      end
   end

   generate
      if (LONG_MODE) begin : g_long
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               lma_q   <= 1'b0;
               cs64_q  <= 1'b0;
               trunc_q <= 1'b0;
            end else begin
               trunc_q <= lm_exit;
               if (lm_enter && pae) begin
                  lma_q <= 1'b1;
               end else if (lm_exit) begin
                  lma_q <= 1'b0;
               end
               if (lm_exit) begin
                  cs64_q <= 1'b0;
               end else if (seg_ld) begin
                  cs64_q <= seg_long & lma_q;
               end
            end
         end
      end else begin : g_legacy
         logic unused_lm;
         assign unused_lm = lme ^ pae ^ seg_long ^ lm_enter ^ lm_exit;
         assign lma_q   = 1'b0;
         assign cs64_q  = 1'b0;
         assign trunc_q = 1'b0;
      end
   endgenerate

   // R2
   et_forced_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cr0_q[MB_ET]);

   // R4
   lma_needs_pae_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(lma_q) |-> pae);

   // R4
   discard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      discard |=> $stable(cr0_q) && !lma_q);

   // R5
   trunc_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
      trunc_q |-> !lma_q && !cs64_q);

endmodule

// File: rtl/ctrlreg_base.sv
module ctrlreg_base
   import ctrlreg_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wr_data,
   input  logic             paging,
   output logic [REG_W-1:0] cr3_q,
   output logic             flush_req
);

   assign flush_req = wr && paging;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr3_q <= '0;
      end else if (wr) begin
         cr3_q <= wr_data;
      end
   end

   // R7
   base_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> cr3_q == $past(wr_data));

endmodule

// File: rtl/ctrlreg_feat.sv
module ctrlreg_feat
   import ctrlreg_pkg::*;
#(
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wr_data,
   input  logic             cap_sse,
   input  logic             cap_smap,
   input  logic             cap_pku,
   input  logic             cap_pks,
   output logic [REG_W-1:0] cr4_q,
   output logic             flush_req
);

   localparam int NCAP = 4;
   localparam int CAP_POS [NCAP] = '{FB_SSE, FB_SMAP, FB_PKE, FB_PKS};
   localparam logic [REG_W-1:0] FLUSH_MASK = (REG_W'(1) << FB_PSE)  |
                                             (REG_W'(1) << FB_PAE)  |
                                             (REG_W'(1) << FB_PGE)  |
                                             (REG_W'(1) << FB_LA57) |
                                             (REG_W'(1) << FB_SMEP) |
                                             (REG_W'(1) << FB_SMAP);

   logic [NCAP-1:0]  cap_vec;
   logic [REG_W-1:0] drop_mask;
   logic [REG_W-1:0] masked;

   assign cap_vec = {cap_pks, cap_pku, cap_smap, cap_sse};

   generate
      for (genvar i = 0; i < NCAP; i++) begin : g_drop
         localparam logic [REG_W-1:0] ONE_BIT = REG_W'(1) << CAP_POS[i];
         logic [REG_W-1:0] part;
         assign part = cap_vec[i] ? '0 : ONE_BIT;
      end
   endgenerate

   always_comb begin
      drop_mask = g_drop[0].part | g_drop[1].part |
                  g_drop[2].part | g_drop[3].part;
      masked    = wr_data & ~drop_mask;
      flush_req = wr && (|((masked ^ cr4_q) & FLUSH_MASK));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cr4_q <= '0;
      end else if (wr) begin
         cr4_q <= masked;
      end
   end

   // R9
   sse_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !cap_sse |=> !cr4_q[FB_SSE]);

   // R9
   smap_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr && !cap_smap |=> !cr4_q[FB_SMAP]);

endmodule

// File: rtl/ctrlreg_write_unit.sv
module ctrlreg_write_unit
   import ctrlreg_pkg::*;
#(
   parameter int REG_W     = 32,
   parameter bit LONG_MODE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             lme,
   input  logic             cap_sse,
   input  logic             cap_smap,
   input  logic             cap_pku,
   input  logic             cap_pks,
   input  logic             seg_ld,
   input  logic             seg_long,
   input  logic             seg_addadd,
   output logic [REG_W-1:0] mode_reg,
   output logic [REG_W-1:0] base_reg,
   output logic [REG_W-1:0] feat_reg,
   output logic [8:0]       hid_flags,
   output logic             lma_out,
   output logic             flush_pulse,
   output logic             trunc_pulse
);

   generate
      if (REG_W < MIN_REG_W) begin : g_width_bad
         $error("ctrlreg_write_unit: REG_W must hold bit 31");
      end
      if (HF_W != 9) begin : g_flag_bad
         $error("ctrlreg_write_unit: hidden flag width mismatch");
      end
   endgenerate

   logic wr_mode, wr_base, wr_feat;
   logic fl_mode, fl_base, fl_feat;
   logic lma_q, cs64_q, addadd_q, flush_q;

   assign wr_mode = wr_en && (wr_sel == SEL_MODE);
   assign wr_base = wr_en && (wr_sel == SEL_BASE);
   assign wr_feat = wr_en && (wr_sel == SEL_FEAT);

   ctrlreg_mode #(.REG_W(REG_W), .LONG_MODE(LONG_MODE)) u_mode (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (wr_mode),
      .wr_data    (wr_data),
      .lme        (lme),
      .pae        (feat_reg[FB_PAE]),
      .seg_ld     (seg_ld),
      .seg_long   (seg_long),
      .seg_addadd (seg_addadd),
      .cr0_q      (mode_reg),
      .lma_q      (lma_q),
      .cs64_q     (cs64_q),
      .addadd_q   (addadd_q),
      .trunc_q    (trunc_pulse),
      .flush_req  (fl_mode)
   );

   ctrlreg_base #(.REG_W(REG_W)) u_base (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_base),
      .wr_data   (wr_data),
      .paging    (mode_reg[MB_PG]),
      .cr3_q     (base_reg),
      .flush_req (fl_base)
   );

   ctrlreg_feat #(.REG_W(REG_W)) u_feat (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (wr_feat),
      .wr_data   (wr_data),
      .cap_sse   (cap_sse),
      .cap_smap  (cap_smap),
      .cap_pku   (cap_pku),
      .cap_pks   (cap_pks),
      .cr4_q     (feat_reg),
      .flush_req (fl_feat)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flush_q <= 1'b0;
      end else begin
         flush_q <= fl_mode | fl_base | fl_feat;
      end
   end

   assign flush_pulse = flush_q;
   assign lma_out     = lma_q;

   always_comb begin
      hid_flags          = '0;
      hid_flags[HF_PROT] = mode_reg[MB_PE];
      hid_flags[HF_ADD]  = addadd_q | ~mode_reg[MB_PE];
      hid_flags[HF_MP]   = mode_reg[MB_MP];
      hid_flags[HF_EM]   = mode_reg[MB_EM];
      hid_flags[HF_TS]   = mode_reg[MB_TS];
      hid_flags[HF_LMA]  = lma_q;
      hid_flags[HF_CS64] = cs64_q;
      hid_flags[HF_SSE]  = feat_reg[FB_SSE];
      hid_flags[HF_SMAP] = feat_reg[FB_SMAP];
   end

   // R7
   base_noflush_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en && wr_sel == SEL_BASE && !mode_reg[MB_PG] |=> !flush_pulse);

   // R10
   flush_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      flush_pulse |-> $past(wr_en) && $past(wr_sel) != SEL_NONE);

   // R6
   addadd_real_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !mode_reg[MB_PE] |-> hid_flags[HF_ADD]);

endmodule

// File: tb/ctrlreg_write_unit_test.sv
`timescale 1ns/1ps
module ctrlreg_write_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_sel = 2'd3;
   logic [31:0] wr_data = '0;
   logic        lme = 1'b0;
   logic        cap_sse = 1'b1, cap_smap = 1'b1, cap_pku = 1'b1, cap_pks = 1'b1;
   logic        seg_ld = 1'b0, seg_long = 1'b0, seg_addadd = 1'b0;
   logic [31:0] mode_reg, base_reg, feat_reg;
   logic [8:0]  hid_flags;
   logic        lma_out, flush_pulse, trunc_pulse;

   always #5 clk = ~clk;

   ctrlreg_write_unit uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .lme(lme), .cap_sse(cap_sse), .cap_smap(cap_smap),
      .cap_pku(cap_pku), .cap_pks(cap_pks), .seg_ld(seg_ld),
      .seg_long(seg_long), .seg_addadd(seg_addadd), .mode_reg(mode_reg),
      .base_reg(base_reg), .feat_reg(feat_reg), .hid_flags(hid_flags),
      .lma_out(lma_out), .flush_pulse(flush_pulse), .trunc_pulse(trunc_pulse)
   );

   typedef struct {
      logic [31:0] m0, m3, m4;
      logic [8:0]  fl;
      logic        lma, fsh, trc;
      string       tag;
   } exp_t;

   exp_t exp_q[$];
   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   // independent model state
   logic [31:0] e0 = 32'h10, e3 = 0, e4 = 0;
   logic        elma = 0, ecs = 0, eadd = 0;

   function automatic logic [8:0] model_flags();
      logic [8:0] f;
      f    = '0;
      f[0] = e0[0];
      f[1] = eadd | ~e0[0];
      f[2] = e0[1];
      f[3] = e0[2];
      f[4] = e0[3];
      f[5] = elma;
      f[6] = ecs;
      f[7] = e4[9];
      f[8] = e4[21];
      return f;
   endfunction

   task automatic op(input bit en, input logic [1:0] sel, input logic [31:0] d,
                     input bit ld, input bit lng, input bit add, input string tag);
      logic fl, tr, enter, exitm;
      logic [31:0] m4;
      @(negedge clk);
      wr_en = en; wr_sel = sel; wr_data = d;
      seg_ld = ld; seg_long = lng; seg_addadd = add;
      fl = 0; tr = 0;
      enter = en && sel == 0 && !e0[31] && d[31] && lme;
      exitm = en && sel == 0 && e0[31] && !d[31] && elma;
      if (ld) begin
         eadd = add;
         ecs  = lng & elma;
      end
      if (en && sel == 0) begin
         if (enter && !e4[5]) begin
            // dropped write
         end else begin
            fl = (d[0] != e0[0]) || (d[16] != e0[16]) || (d[31] != e0[31]);
            if (enter) elma = 1;
            if (exitm) begin elma = 0; ecs = 0; tr = 1; end
            e0 = d | 32'h10;
         end
      end else if (en && sel == 1) begin
         fl = e0[31];
         e3 = d;
      end else if (en && sel == 2) begin
         m4 = d;
         if (!cap_sse)  m4[9]  = 0;
         if (!cap_smap) m4[21] = 0;
         if (!cap_pku)  m4[22] = 0;
         if (!cap_pks)  m4[24] = 0;
         fl = (m4[4] != e4[4]) || (m4[5] != e4[5]) || (m4[7] != e4[7]) ||
              (m4[12] != e4[12]) || (m4[20] != e4[20]) || (m4[21] != e4[21]);
         e4 = m4;
      end
      @(posedge clk);
      exp_q.push_back('{m0:e0, m3:e3, m4:e4, fl:model_flags(), lma:elma,
                        fsh:fl, trc:tr, tag:tag});
      @(negedge clk);
      wr_en = 0; seg_ld = 0; wr_sel = 2'd3;
   endtask

   // monitor: compares at the falling edge after each registered update
   always @(negedge clk) begin
      if (exp_q.size() > 0) begin
         exp_t e;
         e = exp_q.pop_front();
         checks++;
         if (mode_reg !== e.m0 || base_reg !== e.m3 || feat_reg !== e.m4 ||
             hid_flags !== e.fl || lma_out !== e.lma ||
             flush_pulse !== e.fsh || trunc_pulse !== e.trc) begin
            fails++;
            $display("FAIL %s: got m=%h b=%h f=%h hf=%h lma=%b fl=%b tr=%b exp m=%h b=%h f=%h hf=%h lma=%b fl=%b tr=%b",
                     e.tag, mode_reg, base_reg, feat_reg, hid_flags, lma_out,
                     flush_pulse, trunc_pulse, e.m0, e.m3, e.m4, e.fl, e.lma,
                     e.fsh, e.trc);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got hung run exp completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      op(0, 2'd3, 32'h0, 0, 0, 0, "R1 reset state");
      op(1, 2'd0, 32'h0, 0, 0, 0, "R2 ET forced");
      op(1, 2'd0, 32'h0000_000E, 0, 0, 0, "R6 FPU flags R3 no flush");
      op(1, 2'd0, 32'h0000_0001, 0, 0, 0, "R3 PE flush R6 prot");
      op(1, 2'd1, 32'h1234_5000, 0, 0, 0, "R7 base no flush");
      cap_sse = 0; cap_smap = 0; cap_pks = 0;
      op(1, 2'd2, 32'h0160_0220, 0, 0, 0, "R9 masking R8 PAE flush");
      cap_sse = 1; cap_smap = 1; cap_pks = 1;
      op(1, 2'd2, 32'h0040_0220, 0, 0, 0, "R10 R8 SSE only no flush");
      lme = 1;
      op(1, 2'd0, 32'h8000_0001, 0, 0, 0, "R4 long mode entry");
      op(0, 2'd3, 32'h0, 1, 1, 1, "R11 segment load");
      op(1, 2'd1, 32'h0000_9000, 0, 0, 0, "R7 base flush with paging");
      op(1, 2'd0, 32'h0000_0001, 1, 1, 0, "R5 R11 exit with same-cycle load");
      op(1, 2'd2, 32'h0000_0200, 0, 0, 0, "R8 PAE clear flush");
      op(1, 2'd0, 32'h8000_0001, 0, 0, 0, "R4 entry without PAE dropped");
      op(1, 2'd3, 32'hFFFF_FFFF, 0, 0, 0, "R10 select 3 ignored");
      op(1, 2'd2, 32'h0000_1200, 0, 0, 0, "R8 LA57 flush");
      op(1, 2'd2, 32'h0000_1208, 0, 0, 0, "R8 non-listed bit no flush");
      op(1, 2'd0, 32'h0001_0001, 0, 0, 0, "R3 WP flush");
      op(1, 2'd0, 32'h0001_0003, 0, 0, 0, "R3 MP change no flush");
      op(1, 2'd2, 32'h0020_1228, 0, 0, 0, "R10 R8 SMAP flag and flush");
      op(1, 2'd0, 32'h8001_0001, 1, 1, 0, "R4 R11 entry with same-cycle load");
      op(1, 2'd0, 32'h8001_0000, 0, 0, 0, "R6 addadd forced R3 PE flush");
      lme = 0;
      op(0, 2'd3, 32'h0, 0, 0, 0, "R1 settle");
      repeat (3) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
   end

endmodule